// File: doc/BRIEF.md
# Card Data FIFO Transfer Engine

This engine carries block data between a processor register port and a byte-wide card data port. The processor writes the block length and the block count, then starts a transfer in one of two directions. The engine loads a byte down-counter with the product of the two values and moves one byte per beat until the counter is empty.

In the card-bound direction, the processor fills a 32-byte transmit FIFO with register writes of 1 to 4 bytes. Storage for this FIFO is two 32-byte halves, and a partial-buffer command switches from one half to the other. In the processor-bound direction, card bytes collect in a 32-byte receive FIFO and the processor drains it with reads of 1 to 4 bytes. Service requests tell the processor when to refill or drain. Completion flags report the end of a transfer. A stop command aborts a transfer that is in progress.

Top module: `card_xfer_engine`

## Requirements
- R1: After reset, xfer_active, done_data, done_prog, req_tx, req_rx, card_tx_valid and card_rx_ready are all 0.
- R2: Writing select 3 (START) loads the byte counter with BLKCNT (select 2, 16 bits) times BLKLEN (select 1, 12 bits). START bit 0 gives the direction: 1 sends to the card, 0 receives from it. Exactly that many bytes then cross the card port. A product of zero completes without moving any byte.
- R3: The transmit FIFO holds at most 32 bytes. Bytes of a FIFO write (select 6) that arrive while it is full are dropped and never reach the card.
- R4: A FIFO write of N = reg_nbytes_m1+1 bytes queues lane N-1 (bits 8N-1..8N-8) first and lane 0 last.
- R5: A FIFO read of N bytes returns the oldest byte in lane N-1, with younger bytes in the lanes below it. Lanes with no byte left to supply read as zero, and so do all lanes at or above N.
- R6: When sending to the card, card_tx_valid is high while bytes remain and the transmit FIFO is not empty. req_tx rises once bytes remain and the FIFO is empty. A FIFO write clears req_tx.
- R7: When receiving, card_rx_ready is high while bytes remain and the receive FIFO holds fewer than 32 bytes. Each accepted card byte sets req_rx. A FIFO read clears req_rx.
- R8: When the counter reaches zero, xfer_active falls and done_data sets. done_prog also sets, but only for the card-bound direction. START clears both flags.
- R9: Writing select 5 (PARTIAL) with bit 0 set selects the other transmit half and discards every queued byte. With bit 0 clear, the write has no effect.
- R10: Writing select 4 (STOP) with bit 0 set ends the transfer without setting done_data, and it idles the card port.
- R11: At most one byte crosses the card port per clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_sel | input | 3 | Register select (1 BLKLEN, 2 BLKCNT, 3 START, 4 STOP, 5 PARTIAL, 6 FIFO) |
| reg_nbytes_m1 | input | 2 | Access size in bytes minus one |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data; holds receive FIFO bytes while a FIFO read is strobed, otherwise 0 |
| card_tx_data | output | 8 | Byte offered to the card |
| card_tx_valid | output | 1 | card_tx_data is valid |
| card_tx_ready | input | 1 | Card accepts the offered byte |
| card_rx_data | input | 8 | Byte from the card |
| card_rx_valid | input | 1 | card_rx_data is valid |
| card_rx_ready | output | 1 | Engine accepts a card byte |
| xfer_active | output | 1 | Transfer in progress |
| done_data | output | 1 | Data transfer complete |
| done_prog | output | 1 | Card-bound transfer complete |
| req_tx | output | 1 | Transmit FIFO needs refilling |
| req_rx | output | 1 | Receive FIFO has bytes to drain |

## Verification
Several properties are checked on every cycle. At most one byte crosses the card port per cycle. Neither FIFO occupancy goes past 32. An idle engine keeps the card port quiet. done_prog never sets without done_data, and a rising done_data comes with xfer_active low. Every accepted card byte leaves req_rx set, and every FIFO write leaves req_tx clear. Only the bench scenarios can show byte order and lane packing, the dropping of bytes that overflow the transmit FIFO, the exact byte count set by the length product, the discarding done by a half switch, and what a stop does to a live transfer.

// File: rtl/cxe_pkg.sv
package cxe_pkg;
  typedef enum logic [2:0] {
    SEL_NONE    = 3'd0,
    SEL_BLKLEN  = 3'd1,
    SEL_BLKCNT  = 3'd2,
    SEL_START   = 3'd3,
    SEL_STOP    = 3'd4,
    SEL_PARTIAL = 3'd5,
    SEL_FIFO    = 3'd6
  } reg_sel_e;
endpackage

// File: rtl/cxe_tx_fifo.sv
module cxe_tx_fifo #(
  parameter int AW    = 5,
  parameter int LANES = 4,
  parameter int CW    = $clog2(LANES) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 flip,
  input  logic                 push,
  input  logic [CW-1:0]        push_n,
  input  logic [LANES*8-1:0]   push_data,
  input  logic                 pop,
  output logic [AW:0]          count,
  output logic [7:0]           head
);
  localparam int DEPTH = 1 << AW;

  logic          bank_q, bank_d;
  logic [AW-1:0] rd_q, rd_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic [AW:0]   room, req_n, accept;
  logic [7:0]    mem [2*DEPTH];
  logic [AW:0]   waddr [LANES];
  logic [7:0]    wbyte [LANES];
  logic [LANES-1:0] wen;

  always_comb begin
    room   = (AW+1)'(DEPTH) - cnt_q;
    req_n  = (AW+1)'(push_n);
    accept = '0;
    if (push) accept = (req_n < room) ? req_n : room;
    for (int k = 0; k < LANES; k++) begin
      int lane;
      lane     = int'(push_n) - 1 - k;
      wen[k]   = ((AW+1)'(k) < accept);
      waddr[k] = {bank_q, rd_q + cnt_q[AW-1:0] + AW'(k)};
      wbyte[k] = (lane >= 0) ? push_data[lane*8 +: 8] : 8'h00;
    end
    bank_d = bank_q ^ flip;
    if (flip || flush) begin
      cnt_d = '0;
      rd_d  = rd_q;
    end else begin
      cnt_d = cnt_q + accept - (AW+1)'(pop);
      rd_d  = pop ? rd_q + AW'(1) : rd_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bank_q <= 1'b0;
      rd_q   <= '0;
      cnt_q  <= '0;
    end else begin
      bank_q <= bank_d;
      rd_q   <= rd_d;
      cnt_q  <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (wen[k]) mem[waddr[k]] <= wbyte[k];
    end
  end

  assign count = cnt_q;
  assign head  = mem[{bank_q, rd_q}];
endmodule

// File: rtl/cxe_rx_fifo.sv
module cxe_rx_fifo #(
  parameter int AW    = 5,
  parameter int LANES = 4,
  parameter int CW    = $clog2(LANES) + 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 push,
  input  logic [7:0]           push_data,
  input  logic                 pop,
  input  logic [CW-1:0]        pop_n,
  output logic [AW:0]          count,
  output logic [LANES*8-1:0]   pop_data
);
  localparam int DEPTH = 1 << AW;

  logic [AW-1:0] rd_q, rd_d;
  logic [AW:0]   cnt_q, cnt_d;
  logic [AW:0]   req_n, taken;
  logic [7:0]    mem [DEPTH];

  always_comb begin
    req_n    = (AW+1)'(pop_n);
    taken    = '0;
    if (pop) taken = (req_n < cnt_q) ? req_n : cnt_q;
    pop_data = '0;
    for (int k = 0; k < LANES; k++) begin
      int lane;
      lane = int'(pop_n) - 1 - k;
      if (((AW+1)'(k) < taken) && (lane >= 0))
        pop_data[lane*8 +: 8] = mem[rd_q + AW'(k)];
    end
    if (flush) begin
      cnt_d = '0;
      rd_d  = rd_q;
    end else begin
      cnt_d = cnt_q - taken + (AW+1)'(push);
      rd_d  = rd_q + taken[AW-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      rd_q  <= rd_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[rd_q + cnt_q[AW-1:0]] <= push_data;
  end

  assign count = cnt_q;
endmodule

// File: rtl/cxe_ctrl.sv
module cxe_ctrl #(
  parameter int BLKLEN_W = 12,
  parameter int BLKCNT_W = 16,
  parameter int LEFT_W   = BLKLEN_W + BLKCNT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  input  logic                start_wr,
  input  logic [BLKCNT_W-1:0] blkcnt,
  input  logic [BLKLEN_W-1:0] blklen,
  input  logic                stop,
  input  logic                beat,
  input  logic                rx_beat,
  input  logic                tx_empty,
  input  logic                fifo_wr,
  input  logic                fifo_rd,
  output logic                active,
  output logic                dir_wr,
  output logic                left_nz,
  output logic                done_data,
  output logic                done_prog,
  output logic                req_tx,
  output logic                req_rx
);
  logic [LEFT_W-1:0] left_q, left_d;
  logic act_q, act_d, dir_q, dir_d;
  logic dd_q, dd_d, dp_q, dp_d, rt_q, rt_d, rr_q, rr_d;

  always_comb begin
    act_d  = act_q;
    dir_d  = dir_q;
    left_d = left_q;
    dd_d   = dd_q;
    dp_d   = dp_q;
    rt_d   = (rt_q && !fifo_wr) ||
             (act_q && dir_q && (left_q != '0) && tx_empty && !fifo_wr);
    rr_d   = (rr_q && !fifo_rd) || rx_beat;
    if (start) begin
      act_d  = 1'b1;
      dir_d  = start_wr;
      left_d = LEFT_W'(blkcnt) * LEFT_W'(blklen);
      dd_d   = 1'b0;
      dp_d   = 1'b0;
      rt_d   = 1'b0;
      rr_d   = 1'b0;
    end else begin
      if (beat) left_d = left_q - LEFT_W'(1);
      if (stop) begin
        act_d = 1'b0;
      end else if (act_q && (left_q == '0)) begin
        act_d = 1'b0;
        dd_d  = 1'b1;
        dp_d  = dp_q | dir_q;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      dir_q  <= 1'b0;
      left_q <= '0;
      dd_q   <= 1'b0;
      dp_q   <= 1'b0;
      rt_q   <= 1'b0;
      rr_q   <= 1'b0;
    end else begin
      act_q  <= act_d;
      dir_q  <= dir_d;
      left_q <= left_d;
      dd_q   <= dd_d;
      dp_q   <= dp_d;
      rt_q   <= rt_d;
      rr_q   <= rr_d;
    end
  end

  assign active    = act_q;
  assign dir_wr    = dir_q;
  assign left_nz   = (left_q != '0);
  assign done_data = dd_q;
  assign done_prog = dp_q;
  assign req_tx    = rt_q;
  assign req_rx    = rr_q;
endmodule

// File: rtl/card_xfer_engine.sv
module card_xfer_engine #(
  parameter int FIFO_AW  = 5,
  parameter int LANES    = 4,
  parameter int BLKLEN_W = 12,
  parameter int BLKCNT_W = 16,
  parameter int NB_W     = $clog2(LANES)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_wr,
  input  logic                 reg_rd,
  input  logic [2:0]           reg_sel,
  input  logic [NB_W-1:0]      reg_nbytes_m1,
  input  logic [LANES*8-1:0]   reg_wdata,
  output logic [LANES*8-1:0]   reg_rdata,
  output logic [7:0]           card_tx_data,
  output logic                 card_tx_valid,
  input  logic                 card_tx_ready,
  input  logic [7:0]           card_rx_data,
  input  logic                 card_rx_valid,
  output logic                 card_rx_ready,
  output logic                 xfer_active,
  output logic                 done_data,
  output logic                 done_prog,
  output logic                 req_tx,
  output logic                 req_rx
);
  import cxe_pkg::*;

  localparam int DEPTH = 1 << FIFO_AW;
  localparam int CW    = NB_W + 1;

  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic wr_blklen, wr_blkcnt, wr_start, wr_stop, wr_partial, wr_fifo, rd_fifo;
  assign wr_blklen  = reg_wr && (reg_sel == SEL_BLKLEN);
  assign wr_blkcnt  = reg_wr && (reg_sel == SEL_BLKCNT);
  assign wr_start   = reg_wr && (reg_sel == SEL_START);
  assign wr_stop    = reg_wr && (reg_sel == SEL_STOP) && reg_wdata[0];
  assign wr_partial = reg_wr && (reg_sel == SEL_PARTIAL) && reg_wdata[0];
  assign wr_fifo    = reg_wr && (reg_sel == SEL_FIFO);
  assign rd_fifo    = reg_rd && (reg_sel == SEL_FIFO);

  logic [BLKLEN_W-1:0] blklen_q, blklen_d;
  logic [BLKCNT_W-1:0] blkcnt_q, blkcnt_d;

  always_comb begin
    blklen_d = blklen_q;
    blkcnt_d = blkcnt_q;
    if (wr_blklen) blklen_d = reg_wdata[BLKLEN_W-1:0];
    if (wr_blkcnt) blkcnt_d = reg_wdata[BLKCNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      blklen_q <= '0;
      blkcnt_q <= '0;
    end else begin
      blklen_q <= blklen_d;
      blkcnt_q <= blkcnt_d;
    end
  end

  logic              active, dir_wr, left_nz;
  logic [FIFO_AW:0]  tx_cnt, rx_cnt;
  logic              tx_fire, rx_fire;
  logic [CW-1:0]     nbytes;

  assign nbytes        = CW'(reg_nbytes_m1) + CW'(1);
  assign card_tx_valid = active && dir_wr && left_nz && (tx_cnt != '0) &&
                         !wr_start && !wr_stop;
  assign card_rx_ready = active && !dir_wr && left_nz &&
                         (rx_cnt < (FIFO_AW+1)'(DEPTH)) && !wr_start && !wr_stop;
  assign tx_fire       = card_tx_valid && card_tx_ready;
  assign rx_fire       = card_rx_valid && card_rx_ready;

  cxe_tx_fifo #(.AW(FIFO_AW), .LANES(LANES), .CW(CW)) u_tx (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .flush     (wr_start),
    .flip      (wr_partial),
    .push      (wr_fifo),
    .push_n    (nbytes),
    .push_data (reg_wdata),
    .pop       (tx_fire),
    .count     (tx_cnt),
    .head      (card_tx_data)
  );

  logic [LANES*8-1:0] rx_word;

  cxe_rx_fifo #(.AW(FIFO_AW), .LANES(LANES), .CW(CW)) u_rx (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .flush     (wr_start),
    .push      (rx_fire),
    .push_data (card_rx_data),
    .pop       (rd_fifo),
    .pop_n     (nbytes),
    .count     (rx_cnt),
    .pop_data  (rx_word)
  );

  assign reg_rdata = rd_fifo ? rx_word : '0;

  cxe_ctrl #(.BLKLEN_W(BLKLEN_W), .BLKCNT_W(BLKCNT_W)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .start     (wr_start),
    .start_wr  (reg_wdata[0]),
    .blkcnt    (blkcnt_q),
    .blklen    (blklen_q),
    .stop      (wr_stop),
    .beat      (tx_fire || rx_fire),
    .rx_beat   (rx_fire),
    .tx_empty  (tx_cnt == '0),
    .fifo_wr   (wr_fifo),
    .fifo_rd   (rd_fifo),
    .active    (active),
    .dir_wr    (dir_wr),
    .left_nz   (left_nz),
    .done_data (done_data),
    .done_prog (done_prog),
    .req_tx    (req_tx),
    .req_rx    (req_rx)
  );

  assign xfer_active = active;
endmodule

// File: rtl/cxe_checker.sv
module cxe_checker #(
  parameter int FIFO_AW = 5
) (
  input logic             clk,
  input logic             rst_int_n,
  input logic             reg_wr,
  input logic [2:0]       reg_sel,
  input logic             card_tx_valid,
  input logic             card_tx_ready,
  input logic             card_rx_valid,
  input logic             card_rx_ready,
  input logic             xfer_active,
  input logic             dir_wr,
  input logic             done_data,
  input logic             done_prog,
  input logic             req_tx,
  input logic             req_rx,
  input logic [FIFO_AW:0] tx_cnt,
  input logic [FIFO_AW:0] rx_cnt
);
  localparam int DEPTH = 1 << FIFO_AW;

  p_one_byte_r11: assert property (@(posedge clk) disable iff (!rst_int_n)
    $countones({card_tx_valid && card_tx_ready, card_rx_valid && card_rx_ready}) <= 1);

  p_tx_bound_r3: assert property (@(posedge clk) disable iff (!rst_int_n)
    tx_cnt <= (FIFO_AW+1)'(DEPTH));

  p_rx_bound_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    rx_cnt <= (FIFO_AW+1)'(DEPTH));

  p_rx_dir_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    card_rx_ready |-> !dir_wr);

  p_idle_port_r10: assert property (@(posedge clk) disable iff (!rst_int_n)
    !xfer_active |-> (!card_tx_valid && !card_rx_ready));

  p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    $rose(done_data) |-> !xfer_active);

  p_prog_has_data_r8: assert property (@(posedge clk) disable iff (!rst_int_n)
    done_prog |-> done_data);

  p_rx_req_set_r7: assert property (@(posedge clk) disable iff (!rst_int_n)
    (card_rx_valid && card_rx_ready) |=> req_rx);

  p_tx_req_clear_r6: assert property (@(posedge clk) disable iff (!rst_int_n)
    (reg_wr && reg_sel == 3'd6) |=> !req_tx);
endmodule

bind card_xfer_engine cxe_checker #(.FIFO_AW(FIFO_AW)) u_chk (
  .clk           (clk),
  .rst_int_n     (rst_int_n),
  .reg_wr        (reg_wr),
  .reg_sel       (reg_sel),
  .card_tx_valid (card_tx_valid),
  .card_tx_ready (card_tx_ready),
  .card_rx_valid (card_rx_valid),
  .card_rx_ready (card_rx_ready),
  .xfer_active   (xfer_active),
  .dir_wr        (dir_wr),
  .done_data     (done_data),
  .done_prog     (done_prog),
  .req_tx        (req_tx),
  .req_rx        (req_rx),
  .tx_cnt        (tx_cnt),
  .rx_cnt        (rx_cnt)
);

// File: tb/card_xfer_engine_tb.sv
`timescale 1ns/1ps
module card_xfer_engine_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]  reg_sel = 3'd0;
  logic [1:0]  reg_nbytes_m1 = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [7:0]  card_tx_data;
  logic        card_tx_valid;
  logic        card_tx_ready = 1'b0;
  logic [7:0]  card_rx_data = '0;
  logic        card_rx_valid = 1'b0;
  logic        card_rx_ready;
  logic        xfer_active, done_data, done_prog, req_tx, req_rx;

  int vectors = 0;
  int miscompares = 0;
  logic [7:0] exp_q [$];
  logic       feed_en = 1'b0;
  logic [7:0] rx_byte = 8'h00;
  logic       rx_fire_q = 1'b0;
  logic [7:0] rx_base;

  always #2.5 clk = ~clk;

  card_xfer_engine u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_sel(reg_sel), .reg_nbytes_m1(reg_nbytes_m1), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .card_tx_data(card_tx_data),
    .card_tx_valid(card_tx_valid), .card_tx_ready(card_tx_ready),
    .card_rx_data(card_rx_data), .card_rx_valid(card_rx_valid),
    .card_rx_ready(card_rx_ready), .xfer_active(xfer_active),
    .done_data(done_data), .done_prog(done_prog), .req_tx(req_tx),
    .req_rx(req_rx)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: card-bound bytes against the scoreboard queue
  always begin
    @(negedge clk);
    #1;
    if (card_tx_valid && card_tx_ready) begin
      vectors++;
      if (exp_q.size() == 0) begin
        miscompares++;
        $display("FAIL R3 unexpected card byte actual=%h expected=none", card_tx_data);
      end else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        if (card_tx_data !== e) begin
          miscompares++;
          $display("FAIL R4 card byte actual=%h expected=%h", card_tx_data, e);
        end
      end
    end
  end

  // card source model
  always begin
    @(negedge clk);
    if (rx_fire_q) rx_byte = rx_byte + 8'd1;
    card_rx_valid = feed_en;
    card_rx_data  = rx_byte;
    #1;
    rx_fire_q = card_rx_valid && card_rx_ready;
  end

  initial begin
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  task automatic reg_write(input logic [2:0] sel, input logic [31:0] d, input int nb);
    @(negedge clk);
    reg_wr = 1'b1; reg_sel = sel; reg_wdata = d; reg_nbytes_m1 = 2'(nb - 1);
    @(negedge clk);
    reg_wr = 1'b0;
    #1;
  endtask

  // driver: FIFO write, pushing the first nexp bytes (top lane first) as expected
  task automatic tx_push(input logic [31:0] d, input int nb, input int nexp);
    for (int k = 0; k < nexp; k++) exp_q.push_back(d[(nb-1-k)*8 +: 8]);
    reg_write(3'd6, d, nb);
  endtask

  task automatic rx_read(input int nb, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_rd = 1'b1; reg_sel = 3'd6; reg_nbytes_m1 = 2'(nb - 1);
    #1;
    check(reg_rdata, exp, tag);
    @(negedge clk);
    reg_rd = 1'b0;
    #1;
  endtask

  function automatic logic [31:0] rx_exp(input int nb, input int first, input int avail);
    logic [31:0] v;
    v = '0;
    for (int k = 0; k < nb; k++)
      if (k < avail) v[(nb-1-k)*8 +: 8] = rx_base + 8'(first + k);
    return v;
  endfunction

  task automatic start_xfer(input int blen, input int bcnt, input logic wr);
    reg_write(3'd1, 32'(blen), 2);
    reg_write(3'd2, 32'(bcnt), 2);
    reg_write(3'd3, {31'd0, wr}, 1);
  endtask

  task automatic wait_done(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      #1;
      if (done_data) break;
    end
  endtask

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    wait_cycles(4);
    // R1 reset state
    check({27'd0, xfer_active, done_data, done_prog, req_tx, req_rx}, 32'd0, "R1 flags");
    check({30'd0, card_tx_valid, card_rx_ready}, 32'd0, "R1 port idle");

    // R2/R4: 3 blocks of 3 bytes, card ready at once
    @(negedge clk); card_tx_ready = 1'b1;
    start_xfer(3, 3, 1'b1);
    tx_push(32'h11223344, 4, 4);
    tx_push(32'h00005566, 2, 2);
    tx_push(32'h00778899, 3, 3);
    wait_done(100);
    wait_cycles(2);
    check(done_data, 1'b1, "R8 write done_data");
    check(done_prog, 1'b1, "R8 write done_prog");
    check(xfer_active, 1'b0, "R8 write inactive");
    check(exp_q.size(), 0, "R2 all nine bytes sent");

    // R3/R6: overflow, then refill on request
    @(negedge clk); card_tx_ready = 1'b0;
    start_xfer(40, 1, 1'b1);
    check(done_data, 1'b0, "R8 start clears done");
    for (int w = 0; w < 8; w++) tx_push(32'hA0A1A2A3 + 32'(w) * 32'h04040404, 4, 4);
    tx_push(32'hEEEEEEEE, 4, 0);
    check(card_tx_valid, 1'b1, "R6 valid with data");
    @(negedge clk); card_tx_ready = 1'b1;
    wait_cycles(40);
    check(exp_q.size(), 0, "R3 only 32 bytes sent");
    check(req_tx, 1'b1, "R6 req_tx when empty");
    check(card_tx_valid, 1'b0, "R6 no valid when empty");
    check(xfer_active, 1'b1, "R2 still active with 8 left");
    tx_push(32'h01020304, 4, 4);
    check(req_tx, 1'b0, "R6 write clears req_tx");
    tx_push(32'h05060708, 4, 4);
    wait_done(100);
    check(done_prog, 1'b1, "R2 forty bytes complete");
    check(exp_q.size(), 0, "R2 forty bytes sent");

    // R9: partial-buffer command
    @(negedge clk); card_tx_ready = 1'b0;
    start_xfer(8, 1, 1'b1);
    tx_push(32'hC1C2C3C4, 4, 4);
    reg_write(3'd5, 32'h0, 1);
    @(negedge clk); card_tx_ready = 1'b1;
    wait_cycles(8);
    check(exp_q.size(), 0, "R9 bit0 clear keeps data");
    @(negedge clk); card_tx_ready = 1'b0;
    reg_write(3'd6, 32'hDEADBEEF, 4);
    reg_write(3'd5, 32'h1, 1);
    check(card_tx_valid, 1'b0, "R9 flip empties fifo");
    tx_push(32'h5A6B7C8D, 4, 4);
    @(negedge clk); card_tx_ready = 1'b1;
    wait_done(100);
    check(done_data, 1'b1, "R9 done after flip");
    check(exp_q.size(), 0, "R9 new half sent");

    // R5/R7/R8: read 6 bytes
    @(negedge clk); card_tx_ready = 1'b0;
    rx_base = rx_byte;
    start_xfer(3, 2, 1'b0);
    @(negedge clk); feed_en = 1'b1;
    wait_done(100);
    @(negedge clk); feed_en = 1'b0;
    #1;
    check(done_data, 1'b1, "R8 read done_data");
    check(done_prog, 1'b0, "R8 read no done_prog");
    check(req_rx, 1'b1, "R7 req_rx after bytes");
    check(card_rx_ready, 1'b0, "R7 ready low when done");
    rx_read(4, rx_exp(4, 0, 4), "R5 four byte read");
    check(req_rx, 1'b0, "R7 read clears req_rx");
    rx_read(4, rx_exp(4, 4, 2), "R5 short read zero fill");
    rx_read(2, 32'h0, "R5 empty read");

    // R7/R5: 40-byte read with full FIFO back-pressure
    rx_base = rx_byte;
    start_xfer(10, 4, 1'b0);
    @(negedge clk); feed_en = 1'b1;
    wait_cycles(50);
    check(card_rx_ready, 1'b0, "R7 ready low when full");
    check(xfer_active, 1'b1, "R7 active while full");
    rx_read(1, rx_exp(1, 0, 1), "R5 one byte read");
    rx_read(3, rx_exp(3, 1, 3), "R5 three byte read");
    for (int w = 0; w < 9; w++) begin
      wait_cycles(6);
      rx_read(4, rx_exp(4, 4 + 4*w, 4), "R5 word read");
    end
    wait_done(50);
    check(done_data, 1'b1, "R2 forty byte read done");
    @(negedge clk); feed_en = 1'b0;

    // R10: stop aborts
    start_xfer(100, 1, 1'b0);
    @(negedge clk); feed_en = 1'b1;
    wait_cycles(5);
    reg_write(3'd4, 32'h1, 1);
    @(negedge clk); feed_en = 1'b0;
    wait_cycles(3);
    check(xfer_active, 1'b0, "R10 stop ends transfer");
    check(done_data, 1'b0, "R10 no done after stop");
    check(card_rx_ready, 1'b0, "R10 port idle after stop");

    // R2: zero length
    start_xfer(0, 5, 1'b1);
    wait_cycles(3);
    check(done_data, 1'b1, "R2 zero length done");
    check(xfer_active, 1'b0, "R2 zero length inactive");
    check(card_tx_valid, 1'b0, "R11 no byte on zero length");

    wait_cycles(5);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule